// File: doc/BRIEF.md
# Segmented Receive Ring Address Mapper

This block maps the offsets of one logical receive ring onto physical byte addresses. The ring is built from three separate pieces of memory. A fixed main region of eight bytes sits at a base set by a parameter. Two extra regions follow it, each with a base address and a length taken from configuration inputs. A sampler pulses a strobe each time it stores one byte, and the block moves its write pointer on. A consumer reads the byte at the presented address and pulses a request to move the read pointer on. Both pointers wrap at the total ring length.

When the block is enabled, it captures the configuration and checks it. A length or base out of range, or a stored write pointer that does not fit the new ring, puts the block in a fallback mode. In that mode the ring is only the eight-byte main region, used as two halves, and a single input flag gives the write position. At enable time the read pointer is loaded from the write position, so any stale data is dropped. The sample memories are not part of the block.

Top module: `rx_ring_mapper`

## Requirements
- R1: A ring offset from 0 to 7 maps to address MAIN_BASE + offset (default MAIN_BASE 16'h0F80).
- R2: Offsets 8 to 8+len1-1 map to ext1_base + (offset-8). The next len2 offsets map to ext2_base + (offset-8-len1).
- R3: In segmented mode, each wr_stb_i pulse while enabled moves the write pointer on by one. It wraps to 0 at the total length len1+len2+8.
- R4: A rd_req_i pulse while the ring is not empty moves the read pointer on by one. It wraps to 0 at the total length, which is 8 in fallback mode.
- R5: The ring is empty when the read pointer equals the write position. rd_empty_o is then high, rd_addr_o is 0, and rd_req_i has no effect.
- R6: At enable, a total length above 64 or below 16 selects fallback mode (legacy_o high).
- R7: At enable, an extra base outside 16'hEC00 to 16'hFBFC inclusive selects fallback mode. Both ends of that range are accepted.
- R8: In fallback mode, only the main region is used and the ring length is 8. The write position is 4 while legacy_half_i is high and 0 while it is low. wr_stb_i is ignored.
- R9: At enable, a held write pointer that is not below the new total length selects fallback mode.
- R10: On the rising edge of en_i, the configuration is captured and the read pointer is loaded from the write position, so the ring reads as empty. Changes to the configuration inputs while enabled have no effect.
- R11: While disabled, rd_empty_o is high and rd_addr_o is 0. wr_stb_i is ignored and the held write pointer keeps its value.
- R12: err_o is a sticky flag for an offset past the end of region 2, in which case the address is 0. It stays low from reset under every accepted configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable. A rising edge captures and checks the configuration |
| wr_stb_i | input | 1 | Sampler stored one byte |
| rd_req_i | input | 1 | Consumer took the byte at rd_addr_o |
| legacy_half_i | input | 1 | Fallback write position flag: 1 gives 4, 0 gives 0 |
| ext1_base_i | input | 16 | Base address of extra region 1 |
| ext1_len_i | input | 8 | Length of extra region 1 |
| ext2_base_i | input | 16 | Base address of extra region 2 |
| ext2_len_i | input | 8 | Length of extra region 2 |
| rd_addr_o | output | 16 | Physical address of the next unread byte, 0 when empty |
| rd_empty_o | output | 1 | No unread byte, or block disabled |
| legacy_o | output | 1 | Fallback mode selected at the last enable |
| err_o | output | 1 | Sticky out-of-ring offset flag |

## Verification
The assertions check the following on every cycle:
- both pointers stay inside the active ring length;
- the read pointer wraps at the last offset and holds when the ring is empty;
- the read pointer is loaded from the write position at enable;
- a segmented configuration always has a legal length and bases;
- the captured configuration holds while enabled;
- fallback addresses stay inside the main region;
- no decoded offset falls past region 2.

The exact address sequence across the two region seams and the wrap can only be shown by the bench scenarios. The same holds for the accept and reject decisions at each range boundary, for the stale-pointer rejection, and for strobes being ignored while disabled or in fallback mode. The bench observes all of these through the address and empty outputs.

// File: rtl/rxr_pkg.sv
`timescale 1ns/1ps
package rxr_pkg;
  localparam int N_EXT = 2;
  typedef enum logic {
    MODE_SEG    = 1'b0,
    MODE_LEGACY = 1'b1
  } ring_mode_e;
endpackage

// File: rtl/rxr_cfg_check.sv
`timescale 1ns/1ps
module rxr_cfg_check
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 8,
  parameter int PTR_W = 6,
  parameter int TOT_W = 10,
  parameter int MAIN_LEN = 8,
  parameter int MIN_TOTAL = 16,
  parameter int MAX_TOTAL = 64,
  parameter logic [ADDR_W-1:0] BASE_LO = 16'hEC00,
  parameter logic [ADDR_W-1:0] BASE_HI = 16'hFBFC
) (
  input  logic [N_EXT-1:0][ADDR_W-1:0] base_i,
  input  logic [N_EXT-1:0][LEN_W-1:0]  len_i,
  input  logic [PTR_W-1:0]             wr_ptr_i,
  output logic [TOT_W-1:0]             total_o,
  output ring_mode_e                   mode_o
);
  logic [N_EXT-1:0] base_ok;
  logic len_ok, ptr_ok;

  for (genvar g = 0; g < N_EXT; g++) begin : g_base
    assign base_ok[g] = (base_i[g] >= BASE_LO) && (base_i[g] <= BASE_HI);
  end

  always_comb begin
    total_o = TOT_W'(MAIN_LEN);
    for (int k = 0; k < N_EXT; k++) total_o = total_o + TOT_W'(len_i[k]);
  end

  assign len_ok = (total_o >= TOT_W'(MIN_TOTAL)) && (total_o <= TOT_W'(MAX_TOTAL));
  assign ptr_ok = TOT_W'(wr_ptr_i) < total_o;
  assign mode_o = (&base_ok && len_ok && ptr_ok) ? MODE_SEG : MODE_LEGACY;
endmodule

// File: rtl/rxr_addr_map.sv
`timescale 1ns/1ps
module rxr_addr_map
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 8,
  parameter int PTR_W = 6,
  parameter int MAIN_LEN = 8,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 16'h0F80
) (
  input  logic [PTR_W-1:0]             off_i,
  input  ring_mode_e                   mode_i,
  input  logic [N_EXT-1:0][ADDR_W-1:0] base_i,
  input  logic [N_EXT-1:0][LEN_W-1:0]  len_i,
  output logic [ADDR_W-1:0]            addr_o,
  output logic                         oob_o
);
  localparam int REM_W = ((LEN_W > PTR_W) ? LEN_W : PTR_W) + 1;

  logic [REM_W-1:0] rem;
  logic             hit;

  always_comb begin
    addr_o = '0;
    hit    = 1'b0;
    rem    = REM_W'(off_i);
    if (rem < REM_W'(MAIN_LEN)) begin
      addr_o = MAIN_BASE + ADDR_W'(rem);
      hit    = 1'b1;
    end else begin
      rem = rem - REM_W'(MAIN_LEN);
      for (int k = 0; k < N_EXT; k++) begin
        if (!hit && mode_i == MODE_SEG) begin
          if (rem < REM_W'(len_i[k])) begin
            addr_o = base_i[k] + ADDR_W'(rem);
            hit    = 1'b1;
          end else begin
            rem = rem - REM_W'(len_i[k]);
          end
        end
      end
    end
    oob_o = !hit;
  end
endmodule

// File: rtl/rxr_ptr_ctrl.sv
`timescale 1ns/1ps
module rxr_ptr_ctrl
  import rxr_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int TOT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             load_i,
  input  logic [PTR_W-1:0] load_val_i,
  input  logic             wr_stb_i,
  input  logic             rd_req_i,
  input  ring_mode_e       mode_i,
  input  logic [PTR_W-1:0] half_pos_i,
  input  logic [TOT_W-1:0] total_i,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] rd_q, wr_q, wpos;
  logic [PTR_W:0]   rd_inc, wr_inc;
  logic             rd_adv, wr_adv;

  assign wpos    = (mode_i == MODE_LEGACY) ? half_pos_i : wr_q;
  assign empty_o = (rd_q == wpos);
  assign rd_inc  = {1'b0, rd_q} + 1'b1;
  assign wr_inc  = {1'b0, wr_q} + 1'b1;
  assign rd_adv  = active_i && !load_i && rd_req_i && !empty_o;
  assign wr_adv  = active_i && !load_i && wr_stb_i && (mode_i == MODE_SEG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q <= '0;
      wr_q <= '0;
    end else begin
      if (load_i) rd_q <= load_val_i;
      else if (rd_adv) rd_q <= (TOT_W'(rd_inc) == total_i) ? '0 : rd_inc[PTR_W-1:0];
      if (wr_adv) wr_q <= (TOT_W'(wr_inc) == total_i) ? '0 : wr_inc[PTR_W-1:0];
    end
  end

  assign rd_ptr_o = rd_q;
  assign wr_ptr_o = wr_q;

  p_rd_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> (TOT_W'(rd_q) < total_i));
  p_wr_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && mode_i == MODE_SEG) |-> (TOT_W'(wr_q) < total_i));
  p_rd_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !load_i && rd_req_i && !empty_o && TOT_W'(rd_q) == total_i - 1'b1)
      |=> (rd_q == '0));
  p_empty_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !load_i && empty_o) |=> $stable(rd_q));
  p_load_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (rd_q == $past(load_val_i)));
endmodule

// File: rtl/rx_ring_mapper.sv
`timescale 1ns/1ps
module rx_ring_mapper
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W = 8,
  parameter int MAIN_LEN = 8,
  parameter int MIN_TOTAL = 16,
  parameter int MAX_TOTAL = 64,
  parameter logic [ADDR_W-1:0] MAIN_BASE = 16'h0F80,
  parameter logic [ADDR_W-1:0] BASE_LO = 16'hEC00,
  parameter logic [ADDR_W-1:0] BASE_HI = 16'hFBFC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_stb_i,
  input  logic              rd_req_i,
  input  logic              legacy_half_i,
  input  logic [ADDR_W-1:0] ext1_base_i,
  input  logic [LEN_W-1:0]  ext1_len_i,
  input  logic [ADDR_W-1:0] ext2_base_i,
  input  logic [LEN_W-1:0]  ext2_len_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              rd_empty_o,
  output logic              legacy_o,
  output logic              err_o
);
  localparam int PTR_W = $clog2(MAX_TOTAL);
  localparam int TOT_W = LEN_W + 2;
  localparam int HALF  = MAIN_LEN / 2;

  logic [N_EXT-1:0][ADDR_W-1:0] base_in, base_q;
  logic [N_EXT-1:0][LEN_W-1:0]  len_in, len_q;
  logic [TOT_W-1:0] tot_in, tot_q, ring_total;
  ring_mode_e       mode_in, mode_q;
  logic             en_q, err_q, load, empty, oob;
  logic [PTR_W-1:0] rd_ptr, wr_ptr, half_pos, load_val;
  logic [ADDR_W-1:0] map_addr;

  assign base_in  = {ext2_base_i, ext1_base_i};
  assign len_in   = {ext2_len_i, ext1_len_i};
  assign load     = en_i && !en_q;
  assign half_pos = legacy_half_i ? PTR_W'(HALF) : '0;
  assign load_val = (mode_in == MODE_SEG) ? wr_ptr : half_pos;
  assign ring_total = (mode_q == MODE_LEGACY) ? TOT_W'(MAIN_LEN) : tot_q;

  rxr_cfg_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PTR_W(PTR_W), .TOT_W(TOT_W),
    .MAIN_LEN(MAIN_LEN), .MIN_TOTAL(MIN_TOTAL), .MAX_TOTAL(MAX_TOTAL),
    .BASE_LO(BASE_LO), .BASE_HI(BASE_HI)
  ) u_cfg (
    .base_i(base_in), .len_i(len_in), .wr_ptr_i(wr_ptr),
    .total_o(tot_in), .mode_o(mode_in)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      base_q <= '0;
      len_q  <= '0;
      tot_q  <= TOT_W'(MAIN_LEN);
      mode_q <= MODE_LEGACY;
      err_q  <= 1'b0;
    end else begin
      en_q <= en_i;
      if (load) begin
        base_q <= base_in;
        len_q  <= len_in;
        tot_q  <= tot_in;
        mode_q <= mode_in;
      end
      if (en_q && !empty && oob) err_q <= 1'b1;
    end
  end

  rxr_ptr_ctrl #(.PTR_W(PTR_W), .TOT_W(TOT_W)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .active_i(en_q), .load_i(load),
    .load_val_i(load_val), .wr_stb_i(wr_stb_i), .rd_req_i(rd_req_i),
    .mode_i(mode_q), .half_pos_i(half_pos), .total_i(ring_total),
    .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr), .empty_o(empty)
  );

  rxr_addr_map #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PTR_W(PTR_W),
    .MAIN_LEN(MAIN_LEN), .MAIN_BASE(MAIN_BASE)
  ) u_map (
    .off_i(rd_ptr), .mode_i(mode_q), .base_i(base_q), .len_i(len_q),
    .addr_o(map_addr), .oob_o(oob)
  );

  assign rd_empty_o = !en_q || empty;
  assign rd_addr_o  = (rd_empty_o || oob) ? '0 : map_addr;
  assign legacy_o   = (mode_q == MODE_LEGACY);
  assign err_o      = err_q;

  p_seg_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q == MODE_SEG) |->
      (tot_q >= TOT_W'(MIN_TOTAL) && tot_q <= TOT_W'(MAX_TOTAL)));
  p_seg_base_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q == MODE_SEG) |->
      (base_q[0] >= BASE_LO && base_q[0] <= BASE_HI &&
       base_q[1] >= BASE_LO && base_q[1] <= BASE_HI));
  p_legacy_main_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && mode_q == MODE_LEGACY && !rd_empty_o) |->
      (rd_addr_o >= MAIN_BASE && rd_addr_o < MAIN_BASE + ADDR_W'(MAIN_LEN)));
  p_cfg_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && en_i) |=> ($stable(mode_q) && $stable(tot_q) && $stable(base_q)));
  p_no_oob_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !empty) |-> !oob);
endmodule

// File: tb/rx_ring_mapper_tb_top.sv
`timescale 1ns/1ps
module rx_ring_mapper_tb_top;
  localparam logic [15:0] MB = 16'h0F80;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, wr_stb = 0, rd_req = 0, half = 0;
  logic [15:0] b1 = 0, b2 = 0;
  logic [7:0]  l1 = 0, l2 = 0;
  logic [15:0] addr;
  logic empty, legacy, err;

  int n_chk = 0, n_bad = 0;
  int m_wr = 0, m_rd = 0, m_tot = 8;
  bit m_leg = 1;
  int c_b1, c_b2, c_l1, c_l2;

  always #2.5 clk = ~clk;

  rx_ring_mapper dut_i (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .wr_stb_i(wr_stb), .rd_req_i(rd_req),
    .legacy_half_i(half), .ext1_base_i(b1), .ext1_len_i(l1),
    .ext2_base_i(b2), .ext2_len_i(l2),
    .rd_addr_o(addr), .rd_empty_o(empty), .legacy_o(legacy), .err_o(err)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic chk(string req, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic int wpos();
    return m_leg ? (half ? 4 : 0) : m_wr;
  endfunction

  function automatic int exp_addr(int off);
    if (off < 8) return MB + off;
    off -= 8;
    if (off < c_l1) return c_b1 + off;
    off -= c_l1;
    return c_b2 + off;
  endfunction

  task automatic cfg(int nb1, int nl1, int nb2, int nl2);
    b1 = nb1[15:0]; l1 = nl1[7:0]; b2 = nb2[15:0]; l2 = nl2[7:0];
  endtask

  task automatic enable(string req);
    int tot;
    bit ok;
    tot = int'(l1) + int'(l2) + 8;
    ok = tot >= 16 && tot <= 64 && b1 >= 16'hEC00 && b1 <= 16'hFBFC &&
         b2 >= 16'hEC00 && b2 <= 16'hFBFC && m_wr < tot;
    en = 1;
    step();
    m_leg = !ok;
    m_tot = ok ? tot : 8;
    c_b1 = b1; c_b2 = b2; c_l1 = l1; c_l2 = l2;
    m_rd = wpos();
    chk(req, legacy, m_leg);
    chk("R10", empty, 1);
  endtask

  task automatic disable_blk();
    en = 0;
    step();
  endtask

  task automatic do_write(int n, string req);
    for (int i = 0; i < n; i++) begin
      wr_stb = 1; step(); wr_stb = 0;
      if (en && !m_leg) m_wr = (m_wr + 1 == m_tot) ? 0 : m_wr + 1;
    end
  endtask

  task automatic do_read(int n, string req);
    for (int i = 0; i < n; i++) begin
      chk(req, empty, 0);
      chk(req, addr, exp_addr(m_rd));
      rd_req = 1; step(); rd_req = 0;
      m_rd = (m_rd + 1 == m_tot) ? 0 : m_rd + 1;
    end
  endtask

  task automatic t_reset();
    chk("R11", empty, 1);
    chk("R11", addr, 0);
    chk("R12", err, 0);
  endtask

  task automatic t_segmented();
    cfg(16'hEC10, 20, 16'hF000, 12);
    enable("R6");
    do_write(12, "R3");
    do_read(8, "R1");
    do_read(4, "R2");
    do_write(28, "R3");
    do_read(28, "R2");
    chk("R4", m_rd, 0);
    chk("R5", empty, 1);
    chk("R5", addr, 0);
    rd_req = 1; step(); rd_req = 0;
    do_write(1, "R3");
    do_read(1, "R5");
    chk("R5", empty, 1);
  endtask

  task automatic t_cfg_frozen();
    b1 = 16'h1234; l1 = 8'd2;
    step();
    chk("R10", legacy, 0);
    do_write(8, "R3");
    do_read(8, "R10");
    cfg(16'hEC10, 20, 16'hF000, 12);
  endtask

  task automatic t_disabled();
    disable_blk();
    chk("R11", empty, 1);
    chk("R11", addr, 0);
    do_write(3, "R11");
    enable("R10");
    do_write(1, "R11");
    do_read(1, "R11");
  endtask

  task automatic t_limits();
    disable_blk(); cfg(16'hEC00, 4, 16'hFBFC, 4); enable("R7");
    disable_blk(); cfg(16'hEC00, 4, 16'hF000, 3); enable("R6");
    disable_blk(); cfg(16'hEC00, 28, 16'hF000, 28); enable("R6");
    disable_blk(); cfg(16'hEC00, 29, 16'hF000, 28); enable("R6");
    disable_blk(); cfg(16'hEBFF, 10, 16'hF000, 10); enable("R7");
    disable_blk(); cfg(16'hEC20, 10, 16'hFBFD, 10); enable("R7");
  endtask

  task automatic t_legacy();
    disable_blk();
    half = 1;
    cfg(16'hEC10, 40, 16'hF000, 22);
    enable("R8");
    do_write(2, "R8");
    chk("R8", empty, 1);
    half = 0;
    step();
    do_read(4, "R8");
    chk("R8", empty, 1);
    chk("R8", addr, 0);
  endtask

  task automatic t_stale();
    disable_blk(); cfg(16'hEC10, 20, 16'hF000, 12); enable("R10");
    do_write(40 - m_wr + 30, "R3");
    chk("R3", m_wr, 30);
    disable_blk(); cfg(16'hEC10, 4, 16'hF000, 4); enable("R9");
    disable_blk(); cfg(16'hEC10, 20, 16'hF000, 12); enable("R9");
    do_write(1, "R3");
    do_read(1, "R2");
    chk("R12", err, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    step();
    t_reset();
    t_segmented();
    t_cfg_frozen();
    t_disabled();
    t_limits();
    t_legacy();
    t_stale();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule